// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Unit

This unit turns a logical address, made of a 16-bit segment value or selector and an offset, into a linear address. A requester presents one translation at a time over a valid/ready request port. The unit answers with a one-cycle response pulse that carries the linear address and a fault flag.

In real mode the segment value is shifted left by four bits and added to the low 16 bits of the offset. The result wraps within a 20-bit (1 MB) space and is ready on the cycle after the request is taken. No memory access is made in this mode.

In protected mode the selector picks an 8-byte descriptor from either the global or the local table. The unit reads that descriptor as two 32-bit words through a valid/ready memory port. It then checks the offset against the descriptor's limit and adds the descriptor's base to the 32-bit offset. An offset beyond the limit produces a fault in place of an address.

Top module: `seg_xlate`

## Requirements
- R1: In real mode (`req_prot`=0) the linear address is (`req_sel` × 16 + `req_off[15:0]`) mod 2^20, zero-extended to 32 bits. `req_off[31:16]` is ignored and `rsp_fault` is 0.
- R2: A real-mode request accepted at one clock edge gives `rsp_valid`=1 in the cycle that follows. No `mem_valid` is raised for it.
- R3: In protected mode the descriptor index is `req_sel[15:3]`. `req_sel[2]`=1 selects `ldt_base` and 0 selects `gdt_base`, and `req_sel[1:0]` has no effect. The descriptor address is table base + index × 8.
- R4: A descriptor is read as two requests: first at the descriptor address (low word), then at that address + 4 (high word). `mem_valid` and `mem_addr` stay stable until `mem_ready`. Read data is taken in a cycle with `mem_rvalid`=1.
- R5: Descriptor fields are decoded as follows. Base = {hi[31:24], hi[7:0], lo[31:16]}. Limit = {hi[19:16], lo[15:0]}. When the offset is within the limit, the linear address is (base + `req_off`) mod 2^32.
- R6: When hi[23] is set the limit is counted in 4 KB units, so the effective limit is limit × 4096 + 4095. When hi[23] is clear the limit is in bytes.
- R7: When the offset is greater than the effective limit, the response has `rsp_fault`=1 and `rsp_linear`=0. An offset equal to the limit does not fault.
- R8: `req_ready` is high only while no protected translation is in progress. A request held during a translation is not taken until after that translation's response.
- R9: After reset `req_ready`=1, `rsp_valid`=0 and `mem_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can take a request |
| req_prot | input | 1 | 1 = protected mode, 0 = real mode |
| req_sel | input | 16 | Segment value (real) or selector (protected) |
| req_off | input | 32 | Offset |
| gdt_base | input | 32 | Global table base address |
| ldt_base | input | 32 | Local table base address |
| mem_valid | output | 1 | Descriptor read request |
| mem_ready | input | 1 | Memory takes the read request |
| mem_addr | output | 32 | Byte address of the word being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_linear | output | 32 | Linear address (0 on fault) |
| rsp_fault | output | 1 | Offset beyond the segment limit |

## Verification
A fetch sequencer stuck in the wrong state shows up within a few cycles. Either `req_ready` stays low with no further `mem_valid`, or a second read goes out at an address other than the first plus four. A wrong latched table base or index shows up directly in the captured `mem_addr` of the first read. A wrong decode of the descriptor words shows up only in the response, either as a base off by a shifted field or as a fault or non-fault at exactly the limit boundary. Real-mode errors appear one cycle after acceptance, in the 20-bit wrap case.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_LO_REQ,
      FS_LO_WAIT,
      FS_HI_REQ,
      FS_HI_WAIT
   } fetch_st_e;

   typedef struct packed {
      logic [31:0] base;
      logic [19:0] limit;
      logic        gran;
   } seg_desc_t;

   // Gather the scattered fields of an 8-byte descriptor.
   function automatic seg_desc_t unpack_desc(input logic [31:0] lo, input logic [31:0] hi);
      seg_desc_t d;
      d.base  = {hi[31:24], hi[7:0], lo[31:16]};
      d.limit = {hi[19:16], lo[15:0]};
      d.gran  = hi[23];
      return d;
   endfunction

endpackage

// File: rtl/seg_real_calc.sv
module seg_real_calc #(
   parameter int SEG_W  = 16,
   parameter int REAL_W = 20,
   parameter int OUT_W  = 32
) (
   input  logic [SEG_W-1:0] seg,
   input  logic [OUT_W-1:0] off,
   output logic [OUT_W-1:0] linear
);
   localparam int SHIFT = REAL_W - SEG_W;

   logic [REAL_W-1:0] seg_ext;
   logic [REAL_W-1:0] off_ext;
   logic [REAL_W-1:0] sum;

   always_comb begin
      seg_ext = REAL_W'(seg) << SHIFT;
      off_ext = REAL_W'(off[SEG_W-1:0]);
      sum     = seg_ext + off_ext;
      linear  = OUT_W'(sum);
   end
endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int PAGE_BITS = 12,
   parameter bit GRAN_EN   = 1'b1
) (
   input  seg_desc_t         desc,
   input  logic [ADDR_W-1:0] off,
   output logic [ADDR_W-1:0] linear,
   output logic              fault
);
   logic [ADDR_W-1:0] eff_limit;

   generate
      if (GRAN_EN) begin : g_gran
         always_comb begin
            if (desc.gran) eff_limit = ADDR_W'({desc.limit, {PAGE_BITS{1'b1}}});
            else           eff_limit = ADDR_W'(desc.limit);
         end
      end else begin : g_byte
         always_comb eff_limit = ADDR_W'(desc.limit);
      end
   endgenerate

   always_comb begin
      fault  = off > eff_limit;
      linear = fault ? '0 : desc.base + off;
   end
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SEL_W  = 16,
   parameter int WORD_B = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [SEL_W-1:0]  sel,
   input  logic [ADDR_W-1:0] gdt_base,
   input  logic [ADDR_W-1:0] ldt_base,
   output logic              idle,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   output logic              done,
   output logic [31:0]       desc_lo
);
   localparam int TI_BIT  = 2;
   localparam int IDX_LSB = 3;

   fetch_st_e         state;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] tbl_base;
   logic [SEL_W-1:0]  idx_bytes;

   always_comb begin
      tbl_base  = sel[TI_BIT] ? ldt_base : gdt_base;
      idx_bytes = {sel[SEL_W-1:IDX_LSB], {IDX_LSB{1'b0}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= FS_IDLE;
         addr_q  <= '0;
         desc_lo <= '0;
      end else begin
         case (state)
            FS_IDLE: if (start) begin
               addr_q <= tbl_base + ADDR_W'(idx_bytes);
               state  <= FS_LO_REQ;
            end
            FS_LO_REQ:  if (mem_ready) state <= FS_LO_WAIT;
            FS_LO_WAIT: if (mem_rvalid) begin
               desc_lo <= mem_rdata;
               addr_q  <= addr_q + ADDR_W'(WORD_B);
               state   <= FS_HI_REQ;
            end
            FS_HI_REQ:  if (mem_ready) state <= FS_HI_WAIT;
            FS_HI_WAIT: if (mem_rvalid) state <= FS_IDLE;
            default:    state <= FS_IDLE;
         endcase
      end
   end

   always_comb begin
      idle      = state == FS_IDLE;
      mem_valid = (state == FS_LO_REQ) || (state == FS_HI_REQ);
      mem_addr  = addr_q;
      done      = (state == FS_HI_WAIT) && mem_rvalid;
   end

   // R4: a pending read request holds its address until taken
   a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));

   // R4: the high-word read follows the low-word read by one word
   a_r4_hi_step: assert property (@(posedge clk) disable iff (!rst_n)
      (state == FS_LO_WAIT) && mem_rvalid |=> mem_addr == $past(mem_addr) + ADDR_W'(WORD_B));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int SEL_W   = 16,
   parameter int REAL_W  = 20,
   parameter bit GRAN_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_prot,
   input  logic [SEL_W-1:0]  req_sel,
   input  logic [ADDR_W-1:0] req_off,
   input  logic [ADDR_W-1:0] gdt_base,
   input  logic [ADDR_W-1:0] ldt_base,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_linear,
   output logic              rsp_fault
);
   generate
      if (ADDR_W != 32) begin : g_bad_addr
         $error("seg_xlate: descriptor format needs ADDR_W of 32");
      end
      if (REAL_W <= SEL_W || REAL_W > ADDR_W) begin : g_bad_real
         $error("seg_xlate: REAL_W must exceed SEL_W and fit in ADDR_W");
      end
      if (SEL_W < 4) begin : g_bad_sel
         $error("seg_xlate: selector too narrow");
      end
   endgenerate

   logic              accept;
   logic              start;
   logic              fetch_idle;
   logic              fetch_done;
   logic [31:0]       desc_lo;
   logic [ADDR_W-1:0] off_q;
   logic [ADDR_W-1:0] real_lin;
   logic [ADDR_W-1:0] prot_lin;
   logic              prot_fault;
   seg_desc_t         desc;

   always_comb begin
      req_ready = fetch_idle;
      accept    = req_valid && req_ready;
      start     = accept && req_prot;
      desc      = unpack_desc(desc_lo, mem_rdata);
   end

   seg_real_calc #(.SEG_W(SEL_W), .REAL_W(REAL_W), .OUT_W(ADDR_W)) i_real (
      .seg    (req_sel),
      .off    (req_off),
      .linear (real_lin)
   );

   seg_desc_fetch #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) i_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .sel        (req_sel),
      .gdt_base   (gdt_base),
      .ldt_base   (ldt_base),
      .idle       (fetch_idle),
      .mem_valid  (mem_valid),
      .mem_ready  (mem_ready),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .done       (fetch_done),
      .desc_lo    (desc_lo)
   );

   seg_limit_chk #(.ADDR_W(ADDR_W), .GRAN_EN(GRAN_EN)) i_limit (
      .desc   (desc),
      .off    (off_q),
      .linear (prot_lin),
      .fault  (prot_fault)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q      <= '0;
         rsp_valid  <= 1'b0;
         rsp_linear <= '0;
         rsp_fault  <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         if (start) off_q <= req_off;
         if (accept && !req_prot) begin
            rsp_valid  <= 1'b1;
            rsp_linear <= real_lin;
            rsp_fault  <= 1'b0;
         end else if (fetch_done) begin
            rsp_valid  <= 1'b1;
            rsp_linear <= prot_lin;
            rsp_fault  <= prot_fault;
         end
      end
   end

   // R2: real-mode answer in the next cycle, with no memory traffic
   a_r2_real_next: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !req_prot |=> rsp_valid && !mem_valid);

   // R1: real mode never faults
   a_r1_real_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !req_prot |=> !rsp_fault);

   // R7: a faulting response carries no address
   a_r7_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> rsp_linear == '0);

   // R8: a protected request closes the request port
   a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !req_ready);

   // R8: every response finds the unit idle again
   a_r8_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_ready);
endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_prot = 1'b0;
   logic [15:0] req_sel = '0;
   logic [31:0] req_off = '0;
   logic [31:0] gdt_base = 32'h0000_0100;
   logic [31:0] ldt_base = 32'h0000_0200;
   logic        mem_valid;
   logic        mem_ready;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_linear;
   logic        rsp_fault;

   int nchk = 0;
   int nerr = 0;

   always #5 clk = ~clk;

   seg_xlate i_seg_xlate (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_prot(req_prot),
      .req_sel(req_sel), .req_off(req_off),
      .gdt_base(gdt_base), .ldt_base(ldt_base),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .rsp_valid(rsp_valid), .rsp_linear(rsp_linear), .rsp_fault(rsp_fault)
   );

   // memory model: one-cycle read latency, optional alternating stalls
   logic [31:0] mem [0:255];
   logic        stall_en = 1'b0;
   logic        tgl = 1'b0;
   int          nreq = 0;
   logic [31:0] req_addr [0:3];

   assign mem_ready = stall_en ? tgl : 1'b1;

   always @(posedge clk) begin
      tgl        <= ~tgl;
      mem_rvalid <= 1'b0;
      if (mem_valid && mem_ready) begin
         mem_rvalid <= 1'b1;
         mem_rdata  <= mem[mem_addr[9:2]];
         if (nreq < 4) req_addr[nreq] <= mem_addr;
         nreq <= nreq + 1;
      end
   end

   task automatic put_desc(input logic [31:0] a, input logic [31:0] base,
                           input logic [19:0] lim, input logic g);
      mem[a[9:2]]     = {base[15:0], lim[15:0]};
      mem[a[9:2] + 1] = {base[31:24], g, 3'b000, lim[19:16], 8'h92, base[23:16]};
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // entry: prot, selector, offset, expected linear, expected fault
   localparam int NV = 13;
   localparam logic [81:0] VEC [NV] = '{
      {1'b0, 16'h08F1, 32'h0000_0100, 32'h0000_9010, 1'b0},
      {1'b0, 16'h028F, 32'h0000_0030, 32'h0000_2920, 1'b0},
      {1'b0, 16'hFFFF, 32'hABCD_FFFF, 32'h0000_FFEF, 1'b0},
      {1'b0, 16'h0000, 32'h0000_0000, 32'h0000_0000, 1'b0},
      {1'b1, 16'h0008, 32'h0000_0250, 32'h0004_0250, 1'b0},
      {1'b1, 16'h0008, 32'h0000_FFFF, 32'h0004_FFFF, 1'b0},
      {1'b1, 16'h0008, 32'h0001_0000, 32'h0000_0000, 1'b1},
      {1'b1, 16'h0010, 32'h0001_0FFF, 32'h1235_6677, 1'b0},
      {1'b1, 16'h0010, 32'h0001_1000, 32'h0000_0000, 1'b1},
      {1'b1, 16'h001C, 32'h0000_003A, 32'h0002_A03A, 1'b0},
      {1'b1, 16'h001F, 32'h0000_00FF, 32'h0002_A0FF, 1'b0},
      {1'b1, 16'h001C, 32'h0000_0100, 32'h0000_0000, 1'b1},
      {1'b1, 16'h0018, 32'hFFFF_F000, 32'h0000_2000, 1'b0}
   };

   task automatic run_one(input logic prot, input logic [15:0] sel, input logic [31:0] off,
                          input logic [31:0] exp_lin, input logic exp_fault);
      int lat;
      logic [31:0] dadr;
      dadr = (sel[2] ? ldt_base : gdt_base) + {16'h0, sel[15:3], 3'b000};
      @(negedge clk);
      nreq = 0;
      req_valid = 1'b1; req_prot = prot; req_sel = sel; req_off = off;
      check("R8 ready before request", {31'h0, req_ready}, 32'h1);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      if (prot) check("R8 busy during fetch", {31'h0, req_ready}, 32'h0);
      while (!rsp_valid && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      if (!prot) begin
         check("R2 real latency", lat, 1);
         check("R2 no memory access", nreq, 0);
         check("R1 real linear", rsp_linear, exp_lin);
         check("R1 real fault", {31'h0, rsp_fault}, 32'h0);
      end else begin
         check("R4 read count", nreq, 2);
         check("R3 low-word address", req_addr[0], dadr);
         check("R4 high-word address", req_addr[1], dadr + 32'd4);
         check(exp_fault ? "R7 fault linear" : "R5 R6 linear", rsp_linear, exp_lin);
         check("R7 fault flag", {31'h0, rsp_fault}, {31'h0, exp_fault});
      end
   endtask

   initial begin
      put_desc(32'h108, 32'h0004_0000, 20'h0FFFF, 1'b0);
      put_desc(32'h110, 32'h1234_5678, 20'h00010, 1'b1);
      put_desc(32'h118, 32'h0000_3000, 20'hFFFFF, 1'b1);
      put_desc(32'h218, 32'h0002_A000, 20'h000FF, 1'b0);

      #1;
      check("R9 ready in reset", {31'h0, req_ready}, 32'h1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
      check("R9 mem_valid after reset", {31'h0, mem_valid}, 32'h0);
      check("R9 ready after reset", {31'h0, req_ready}, 32'h1);

      for (int pass = 0; pass < 2; pass++) begin
         stall_en = pass[0];
         for (int i = 0; i < NV; i++)
            run_one(VEC[i][81], VEC[i][80:65], VEC[i][64:33], VEC[i][32:1], VEC[i][0]);
      end

      // R8: a real request held during a protected fetch waits for it
      @(negedge clk);
      req_valid = 1'b1; req_prot = 1'b1; req_sel = 16'h0008; req_off = 32'h10;
      @(negedge clk);
      req_prot = 1'b0; req_sel = 16'h08F1; req_off = 32'h100;
      check("R8 held request refused", {31'h0, req_ready}, 32'h0);
      while (!rsp_valid) @(negedge clk);
      check("R8 first response is protected", rsp_linear, 32'h0004_0010);
      @(negedge clk);
      req_valid = 1'b0;
      check("R8 held real request then served", {31'h0, rsp_valid}, 32'h1);
      check("R8 held real request result", rsp_linear, 32'h0000_9010);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule